// File: doc/BRIEF.md
# Condition-Driven Early-Exit Vector Sequencer

This block walks a vector of length VL one element per cycle, in ascending order from element 0. For each presented result it forms a four-bit condition field: less-than-zero, greater-than-zero, equal-to-zero, and a summary-overflow bit that is always zero here. It then tests one bit of that field against an invert flag. A passing element lets the loop go on. The first failing element stops the walk: that element and every later one are discarded, and a shortened vector length is reported.

The surrounding pipeline pulses `start` with the vector length and the mode bits, then presents one result per cycle on `elem_result` with `elem_valid`. The block returns write enables for the result register and the condition register of the element currently presented. When the walk ends it pulses `done` and holds the final length on `vl_out`. A compare-only mode turns the operation into a pure comparison: condition fields are written and results never are. The length shrinks only on an explicit test failure, and it may shrink to zero.

Top module: `ffirst_seq`

## Requirements
- R1: For each presented element, `cr_out` shows the condition field of `elem_result`, read as a signed number. Bit 3 is less-than-zero, bit 2 is greater-than-zero, bit 1 is equal-to-zero, and bit 0 is always 0.
- R2: With `rc`=0 the tested bit is always the equal bit (bit 1) and `crbit_sel` is ignored. With `rc`=1 the tested bit is selected by `crbit_sel`: 0 selects less-than, 1 greater-than, 2 equal, 3 summary. An element passes when the tested bit differs from `inv`.
- R3: On the first failing element at index i, the walk stops and `vl_out` becomes i, or i+1 when `vli`=1 and `rc`=0. With `rc`=1, `vli` has no effect.
- R4: `res_we` is high for every passing element. It is also high for the failing element when the inclusive count applies. It is never high while `rc1`=1 (compare-only).
- R5: `cr_we` is high for every processed element, including a failing one, when `rc`=1 or `rc1`=1. Otherwise it stays low.
- R6: Elements are numbered on `elem_idx` from 0 upward. A cycle with `elem_valid` low produces no write and does not advance `elem_idx`.
- R7: If no element fails, `vl_out` keeps the started length and `done` pulses for one cycle in the cycle after element VL-1.
- R8: A start with length 0 pulses `done` in the next cycle and leaves `vl_out` at 0. A vector whose element 0 fails without the inclusive count also ends with `vl_out` at 0.
- R9: After reset, `done`, `res_we` and `cr_we` are low and `vl_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk; sampled while idle |
| vl_in | input | 7 | Vector length for the walk |
| rc | input | 1 | Condition-record form: selectable bit, condition writes |
| rc1 | input | 1 | Compare-only: condition writes, no result writes |
| inv | input | 1 | Invert flag for the bit test |
| crbit_sel | input | 2 | Tested bit when `rc`=1 |
| vli | input | 1 | Inclusive count on failure (only with `rc`=0) |
| elem_valid | input | 1 | A result is presented this cycle |
| elem_result | input | 64 | Signed result of the current element |
| res_we | output | 1 | Write the current result |
| cr_we | output | 1 | Write the current condition field |
| cr_out | output | 4 | Condition field of the current element |
| elem_idx | output | 7 | Index of the current element |
| vl_out | output | 7 | Vector length, truncated on failure |
| done | output | 1 | One-cycle pulse when the walk ends |

## Verification
A failure and the natural end of the vector can fall on the same element. This is provoked by making the last element fail with the inclusive count set. The truncated length i+1 then equals the started length, and the bench expects `vl_out` unchanged, a single `done` pulse and a result write for that element. A failure on element 0 is also driven, where truncation and an immediate end coincide. A stall cycle is placed inside a walk to show that the index holds across it.

// File: rtl/ffseq_pkg.sv
package ffseq_pkg;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    typedef struct packed {
        logic       rc;
        logic       rc1;
        logic       inv;
        logic [1:0] sel;
        logic       vli;
    } mode_t;

    typedef enum logic {SQ_IDLE, SQ_RUN} sq_state_e;

    localparam logic [1:0] SEL_EQ = 2'd2;

    function automatic logic pick_bit(input cond_t c, input logic [1:0] sel);
        logic b;
        case (sel)
            2'd0:    b = c.lt;
            2'd1:    b = c.gt;
            2'd2:    b = c.eq;
            default: b = c.so;
        endcase
        return b;
    endfunction

    function automatic logic [1:0] eff_sel(input mode_t m);
        return m.rc ? m.sel : SEL_EQ;
    endfunction

    function automatic logic incl_cnt(input mode_t m);
        return m.vli & ~m.rc;
    endfunction

endpackage

// File: rtl/ffseq_cond.sv
module ffseq_cond
    import ffseq_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] result,
    input  logic [1:0]        sel,
    input  logic              inv,
    output cond_t             cond,
    output logic              pass
);
    logic is_zero;
    logic is_neg;

    always_comb begin
        is_zero = (result == '0);
        is_neg  = result[DATA_W-1];
        cond.lt = is_neg;
        cond.eq = is_zero;
        cond.gt = ~is_neg & ~is_zero;
        cond.so = 1'b0;
        pass    = pick_bit(cond, sel) ^ inv;
    end
endmodule

// File: rtl/ffseq_wrctl.sv
module ffseq_wrctl (
    input  logic go,
    input  logic pass,
    input  logic cmp_only,
    input  logic incl,
    input  logic cr_en,
    output logic res_we,
    output logic cr_we
);
    always_comb begin
        res_we = go & ~cmp_only & (pass | incl);
        cr_we  = go & cr_en;
    end
endmodule

// File: rtl/ffseq_ctrl.sv
module ffseq_ctrl
    import ffseq_pkg::*;
#(
    parameter int VL_W = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [VL_W-1:0] vl_in,
    input  mode_t           mode_in,
    input  logic            elem_valid,
    input  logic            pass,
    output logic            running,
    output logic [VL_W-1:0] idx,
    output logic [VL_W-1:0] vl_out,
    output logic            done,
    output mode_t           mode_q
);
    localparam logic [VL_W-1:0] ONE = VL_W'(1);

    sq_state_e       state_q;
    logic [VL_W-1:0] idx_q;
    logic [VL_W-1:0] vl_q;
    logic [VL_W-1:0] vl_o_q;
    logic            done_q;
    mode_t           mode_r;
    logic            last_elem;

    assign last_elem = ((idx_q + ONE) == vl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            vl_q    <= '0;
            vl_o_q  <= '0;
            done_q  <= 1'b0;
            mode_r  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        mode_r <= mode_in;
                        vl_q   <= vl_in;
                        vl_o_q <= vl_in;
                        idx_q  <= '0;
                        if (vl_in == '0) done_q  <= 1'b1;
                        else             state_q <= SQ_RUN;
                    end
                end
                default: begin
                    if (elem_valid) begin
                        if (!pass) begin
                            vl_o_q  <= idx_q + {{(VL_W-1){1'b0}}, incl_cnt(mode_r)};
                            done_q  <= 1'b1;
                            state_q <= SQ_IDLE;
                        end else if (last_elem) begin
                            done_q  <= 1'b1;
                            state_q <= SQ_IDLE;
                        end else begin
                            idx_q <= idx_q + ONE;
                        end
                    end
                end
            endcase
        end
    end

    assign running = (state_q == SQ_RUN);
    assign idx     = idx_q;
    assign vl_out  = vl_o_q;
    assign done    = done_q;
    assign mode_q  = mode_r;

    // R6
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_RUN) |-> (idx_q < vl_q));

    // R6
    idx_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_RUN && !elem_valid) |=> $stable(idx_q));

    // R3
    vl_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_RUN) |=> (vl_o_q <= $past(vl_o_q)));

    // R7
    pass_keeps_vl_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_RUN && elem_valid && pass) |=> $stable(vl_o_q));

    // R8
    zero_vl_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_IDLE && start && vl_in == '0) |=> (done_q && vl_o_q == '0));
endmodule

// File: rtl/ffirst_seq.sv
module ffirst_seq
    import ffseq_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int VL_W   = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VL_W-1:0]   vl_in,
    input  logic              rc,
    input  logic              rc1,
    input  logic              inv,
    input  logic [1:0]        crbit_sel,
    input  logic              vli,
    input  logic              elem_valid,
    input  logic [DATA_W-1:0] elem_result,
    output logic              res_we,
    output logic              cr_we,
    output logic [3:0]        cr_out,
    output logic [VL_W-1:0]   elem_idx,
    output logic [VL_W-1:0]   vl_out,
    output logic              done
);
    mode_t mode_in;
    mode_t mode_q;
    cond_t cond;
    logic  pass;
    logic  running;
    logic  go;

    assign mode_in = '{rc: rc, rc1: rc1, inv: inv, sel: crbit_sel, vli: vli};
    assign go      = running & elem_valid;
    assign cr_out  = cond;

    ffseq_ctrl #(.VL_W(VL_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .vl_in      (vl_in),
        .mode_in    (mode_in),
        .elem_valid (elem_valid),
        .pass       (pass),
        .running    (running),
        .idx        (elem_idx),
        .vl_out     (vl_out),
        .done       (done),
        .mode_q     (mode_q)
    );

    ffseq_cond #(.DATA_W(DATA_W)) u_cond (
        .result (elem_result),
        .sel    (eff_sel(mode_q)),
        .inv    (mode_q.inv),
        .cond   (cond),
        .pass   (pass)
    );

    ffseq_wrctl u_wr (
        .go       (go),
        .pass     (pass),
        .cmp_only (mode_q.rc1),
        .incl     (incl_cnt(mode_q)),
        .cr_en    (mode_q.rc | mode_q.rc1),
        .res_we   (res_we),
        .cr_we    (cr_we)
    );

    // R4
    cmp_only_chk: assert property (@(posedge clk) disable iff (rst)
        res_we |-> !mode_q.rc1);

    // R6
    we_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (res_we || cr_we) |-> (elem_valid && running));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!res_we && !cr_we));
endmodule

// File: tb/sim_ffirst_seq.sv
module sim_ffirst_seq;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit         is_end;
        bit         rwe;
        bit         cwe;
        bit [3:0]   cr;
        int         idx;
        int         vl;
        string      tag;
    } exp_t;

    typedef logic signed [63:0] vec_t [8];

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  vl_in = '0;
    logic        rc = 1'b0, rc1 = 1'b0, inv = 1'b0, vli = 1'b0;
    logic [1:0]  crbit_sel = '0;
    logic        elem_valid = 1'b0;
    logic [63:0] elem_result = '0;
    logic        res_we, cr_we, done;
    logic [3:0]  cr_out;
    logic [6:0]  elem_idx, vl_out;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];
    event sb_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    ffirst_seq u0 (
        .clk(clk), .rst(rst), .start(start), .vl_in(vl_in), .rc(rc), .rc1(rc1),
        .inv(inv), .crbit_sel(crbit_sel), .vli(vli), .elem_valid(elem_valid),
        .elem_result(elem_result), .res_we(res_we), .cr_we(cr_we), .cr_out(cr_out),
        .elem_idx(elem_idx), .vl_out(vl_out), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    function automatic bit [3:0] cr_model(input logic signed [63:0] v);
        return {v < 0, v > 0, v == 0, 1'b0};
    endfunction

    // monitor: pops expected items and compares to the outputs
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.is_end) begin
                    check(done == 1'b1, {e.tag, " done"}, int'(done), 1);
                    check(vl_out == e.vl, {e.tag, " vl_out"}, int'(vl_out), e.vl);
                end else begin
                    check(res_we == e.rwe, {e.tag, " R4 res_we"}, int'(res_we), int'(e.rwe));
                    check(cr_we == e.cwe, {e.tag, " R5 cr_we"}, int'(cr_we), int'(e.cwe));
                    check(cr_out == e.cr, {e.tag, " R1 cr_out"}, int'(cr_out), int'(e.cr));
                    check(elem_idx == e.idx, {e.tag, " R6 elem_idx"}, int'(elem_idx), e.idx);
                end
            end
        end
    end

    task automatic push(input exp_t e);
        sb_q.push_back(e);
        ->sb_ev;
    endtask

    task automatic run_vec(input int vl, input bit m_rc, input bit m_rc1, input bit m_inv,
                           input bit [1:0] m_sel, input bit m_vli, input vec_t v,
                           input int gap_at, input string tag);
        int  new_vl;
        bit  inc;
        exp_t e;
        inc    = m_vli & ~m_rc;
        new_vl = vl;
        @(negedge clk);
        start = 1'b1; vl_in = 7'(vl); rc = m_rc; rc1 = m_rc1; inv = m_inv;
        crbit_sel = m_sel; vli = m_vli;
        @(negedge clk);
        start = 1'b0; rc = 1'b0; rc1 = 1'b0; inv = 1'b0; crbit_sel = '0; vli = 1'b0;
        for (int i = 0; i < vl; i++) begin
            bit [3:0] c;
            bit       b;
            bit       ps;
            if (i == gap_at) begin
                elem_valid = 1'b0; elem_result = '0;
                #1;
                e = '{is_end: 0, rwe: 0, cwe: 0, cr: 4'b0010, idx: i, vl: 0, tag: {tag, " R6 stall"}};
                push(e);
                @(negedge clk);
            end
            c  = cr_model(v[i]);
            b  = m_rc ? c[3 - m_sel] : c[1];
            ps = (b != m_inv);
            elem_valid = 1'b1; elem_result = v[i];
            #1;
            e = '{is_end: 0, rwe: !m_rc1 && (ps || inc), cwe: m_rc || m_rc1,
                  cr: c, idx: i, vl: 0, tag: {tag, " R2"}};
            push(e);
            @(negedge clk);
            if (!ps) begin
                new_vl = i + int'(inc);
                break;
            end
        end
        elem_valid = 1'b0; elem_result = '0;
        #1;
        e = '{is_end: 1, rwe: 0, cwe: 0, cr: 0, idx: 0, vl: new_vl, tag: {tag, " R3"}};
        push(e);
        @(negedge clk);
        #1;
        check(done == 1'b0, {tag, " R7 done single pulse"}, int'(done), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R9 reset state
        check(done == 1'b0, "R9 done", int'(done), 0);
        check(vl_out == 7'd0, "R9 vl_out", int'(vl_out), 0);
        check(res_we == 1'b0 && cr_we == 1'b0, "R9 write enables", int'({res_we, cr_we}), 0);

        // R3 inclusive count stops at a zero, zero included
        run_vec(5, 0, 0, 1, 2'd0, 1, '{3, -2, 7, 0, 9, 0, 0, 0}, -1, "incl");
        // R3 exclusive count
        run_vec(5, 0, 0, 1, 2'd3, 0, '{3, -2, 7, 0, 9, 0, 0, 0}, -1, "excl");
        // R8 element 0 fails, length becomes zero
        run_vec(4, 0, 0, 1, 2'd0, 0, '{0, 5, 5, 5, 0, 0, 0, 0}, -1, "R8 first fail");
        // R7 nothing fails, with a stall in the middle (R6)
        run_vec(4, 0, 0, 1, 2'd0, 0, '{1, -1, 2, 64'sh7fff_ffff_ffff_ffff, 0, 0, 0, 0}, 2, "R7 full");
        // R2 rc=1 on less-than; vli ignored
        run_vec(6, 1, 0, 0, 2'd0, 1, '{-1, -5, 4, -2, -2, -2, 0, 0}, -1, "rc lt");
        // R2 rc=1 on greater-than, inverted
        run_vec(3, 1, 0, 1, 2'd1, 0, '{-3, 0, 5, 0, 0, 0, 0, 0}, -1, "rc gt");
        // R4 compare-only: condition writes, no result writes
        run_vec(5, 0, 1, 0, 2'd0, 0, '{0, 0, 0, 8, 0, 0, 0, 0}, -1, "R4 cmp only");
        // R8 zero length start
        run_vec(0, 0, 0, 0, 2'd0, 0, '{0, 0, 0, 0, 0, 0, 0, 0}, -1, "R8 zero vl");
        // R3 failure on the last element with inclusive count
        run_vec(3, 0, 0, 1, 2'd0, 1, '{1, 1, 0, 0, 0, 0, 0, 0}, 1, "R7 last incl");
        // R5 rc=1 summary bit never set, inv=1 always passes
        run_vec(3, 1, 0, 1, 2'd3, 0, '{-9, 0, 9, 0, 0, 0, 0, 0}, -1, "R5 so");

        #1;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule